// File: doc/BRIEF.md
# Object Attribute Memory Copy Engine

This block copies a fixed run of 160 bytes from a 256-byte page anywhere in a 16-bit address space into the object attribute memory that holds sprite descriptors. Software starts a copy by presenting the page number (the upper address byte) on a one-cycle trigger. After a start delay, the engine reads one byte per slot from the system bus and writes it to the next object-memory index, with a fixed pacing between slots.

While a copy runs, the engine also filters the processor's own accesses. The address space is split into eight 8 KB regions, and each region belongs to a physical bus group. A processor access that lands on the same group as the copy's source is blocked, unless that group is the processor-internal one. Any access to the object-memory window is blocked whatever the groups. A model-select input picks between two region-to-group tables. The object memory, the source memories and the video timing lie outside this block.

Top module: `objcopy_dma`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `remaining` is 0, `mem_wr` and `bus_rd` are 0, and no processor access is blocked.
- R2: A trigger whose page value is 0xF1 or lower is accepted: from the next cycle `busy` is 1 and `remaining` is 160.
- R3: A trigger whose page value is above 0xF1 (a base address above 0xF100) is ignored: while idle, `busy` stays 0 and no byte is written.
- R4: The first byte is committed at the 8th rising edge after the edge that accepts the trigger; each later byte is committed 4 edges after the previous one.
- R5: Byte k (k = 0..159) is read from address {page, 8'h00} + k and written to object index k with the value read; exactly 160 bytes are written, indices 160..255 are never written, and `busy` falls after the last one.
- R6: A valid trigger during a copy abandons it and restarts with the new page, a full count of 160 and the full start delay.
- R7: With `model_sel` = 0, region 0x8000-0x9FFF is the video group, region 0xE000-0xFFFF is the processor-internal group, and all other regions are the main group.
- R8: With `model_sel` = 1, the groups are as in R7 except that region 0xC000-0xDFFF forms a group of its own.
- R9: While `busy`, a processor access is blocked when its region's group equals the group of the copy's source, unless that group is the processor-internal one.
- R10: While `busy`, any processor access to 0xFE00-0xFE9F is blocked, whatever the groups.
- R11: A blocked read returns 0xFF on `cpu_rdata` and a blocked write is not passed on `cpu_wr_pass`; an unblocked access passes the read data and the write strobe unchanged.
- R12: While idle, no processor access is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | One-cycle start request |
| trig_page | input | 8 | Source page (upper address byte) |
| model_sel | input | 1 | Region-to-group table select |
| bus_rd | output | 1 | Read strobe toward the system bus, high in a copy slot |
| bus_addr | output | 16 | Source address for the current slot |
| bus_rdata | input | 8 | Byte returned by the system bus in the same cycle |
| mem_wr | output | 1 | Write strobe into object memory |
| mem_idx | output | 8 | Object memory index |
| mem_wdata | output | 8 | Byte written into object memory |
| cpu_addr | input | 16 | Processor access address |
| cpu_rd | input | 1 | Processor read request |
| cpu_wr | input | 1 | Processor write request |
| cpu_rdata_in | input | 8 | Read data from the processor-side fabric |
| cpu_rdata | output | 8 | Filtered read data to the processor |
| cpu_wr_pass | output | 1 | Filtered write strobe |
| cpu_block | output | 1 | Current processor access is blocked |
| busy | output | 1 | Copy in progress |
| remaining | output | 8 | Bytes still to be copied |

## Verification
The bench goes after the page limit on both sides (0xF1 accepted, 0xF2 ignored): a design that compares against the wrong bound either drops a legal copy from the top page or starts one it should reject. It measures the start delay and every slot gap, so an off-by-one counter shows as a first write one edge early or late or as a drifting pace. It restarts a copy mid-flight and checks that the second page fully overwrites indices 0..159, which catches an engine that keeps the old count or pointers. It walks both group tables at the region edges, including a processor-internal source, the 0xC000 region that differs between models and the last and first addresses around the object window, where a wrong table or window bound blocks or passes the wrong access.

// File: rtl/objcopy_pkg.sv
// Package: shared bus-group type and the region-to-group mapping used by
// the copy engine's access filter.
// Assumes an address space split into eight 8 KB regions (addr[15:13]).
package objcopy_pkg;

    typedef enum logic [1:0] {
        GRP_MAIN  = 2'd0,
        GRP_VIDEO = 2'd1,
        GRP_WRAM  = 2'd2,
        GRP_CORE  = 2'd3
    } grp_e;

    localparam int unsigned REGION_COUNT = 8;
    localparam int unsigned REGION_W     = 3;

    // Maps a region number to its bus group for one hardware model.
    function automatic grp_e region_group(input logic [REGION_W-1:0] region,
                                          input logic second_model);
        grp_e g;
        case (region)
            3'd4:    g = GRP_VIDEO;
            3'd6:    g = second_model ? GRP_WRAM : GRP_MAIN;
            3'd7:    g = GRP_CORE;
            default: g = GRP_MAIN;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/objcopy_sched.sv
// Module: objcopy_sched
// Paces the copy: a start delay after an accepted trigger, then one slot
// every BYTE_GAP cycles until XFER_LEN slots have been issued.
// Assumes START_DLY >= 1 and BYTE_GAP >= 2. A start in the same cycle as a
// slot wins: the slot is suppressed and the schedule restarts.
module objcopy_sched #(
    parameter int unsigned XFER_LEN  = 160,
    parameter int unsigned START_DLY = 8,
    parameter int unsigned BYTE_GAP  = 4,
    localparam int unsigned CNT_W    = $clog2(XFER_LEN + 1),
    localparam int unsigned MAX_DLY  = (START_DLY > BYTE_GAP) ? START_DLY : BYTE_GAP,
    localparam int unsigned WAIT_W   = (MAX_DLY < 2) ? 1 : $clog2(MAX_DLY)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             slot,
    output logic             active,
    output logic [CNT_W-1:0] remaining
);

    logic [CNT_W-1:0]  rem_q;
    logic [WAIT_W-1:0] wait_q;

    // Busy whenever bytes are outstanding.
    assign active    = (rem_q != '0);
    // A slot fires when the wait has run out and no restart is pending.
    assign slot      = active && (wait_q == '0) && !start;
    assign remaining = rem_q;

    // Remaining-count and wait-counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            wait_q <= '0;
        end else if (start) begin
            rem_q  <= CNT_W'(XFER_LEN);
            wait_q <= WAIT_W'(START_DLY - 1);
        end else if (active) begin
            if (wait_q == '0) begin
                rem_q  <= rem_q - 1'b1;
                wait_q <= WAIT_W'(BYTE_GAP - 1);
            end else begin
                wait_q <= wait_q - 1'b1;
            end
        end
    end

    // R5: the count never exceeds one full transfer.
    p_count_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q <= CNT_W'(XFER_LEN));

    // R4: two slots are never adjacent.
    p_slot_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        slot |=> !slot);

    // R5: each slot consumes exactly one byte of the count.
    p_slot_decrement_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot |=> (rem_q == $past(rem_q) - 1'b1));

    // R6: a start always reloads the full count.
    p_restart_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (rem_q == CNT_W'(XFER_LEN)));

endmodule

// File: rtl/objcopy_addr.sv
// Module: objcopy_addr
// Holds the source address and the object-memory index of the copy.
// Both start at the page base / zero on a start and step by one per slot.
// Assumes start and slot are never high together (the scheduler ensures it).
module objcopy_addr #(
    parameter int unsigned XFER_LEN = 160,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned IDX_W    = 8,
    localparam int unsigned PAGE_W  = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page,
    input  logic              slot,
    output logic [ADDR_W-1:0] src,
    output logic [IDX_W-1:0]  dst
);

    // Pointer load on start, increment on every slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src <= '0;
            dst <= '0;
        end else if (start) begin
            src <= {page, {IDX_W{1'b0}}};
            dst <= '0;
        end else if (slot) begin
            src <= src + 1'b1;
            dst <= dst + 1'b1;
        end
    end

    // R5: a slot only ever targets an index inside the transfer.
    p_idx_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot |-> (int'(dst) < XFER_LEN));

    // R5: source and index advance together.
    p_step_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
        slot |=> (src[IDX_W-1:0] == dst));

endmodule

// File: rtl/objcopy_guard.sv
// Module: objcopy_guard
// Decides whether a processor access must be blocked while a copy runs.
// Builds the two region-to-group tables with generate and selects one by
// model; also blocks the object-memory window outright.
// Assumes the source region is constant during a copy (one page per copy).
module objcopy_guard
    import objcopy_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter logic [15:0] OBJ_BASE = 16'hFE00,
    parameter int unsigned OBJ_SPAN = 160,
    localparam int unsigned REG_LSB = ADDR_W - REGION_W
) (
    input  logic              active,
    input  logic              model_sel,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              block
);

    grp_e tbl_first  [REGION_COUNT];
    grp_e tbl_second [REGION_COUNT];

    // One table entry per region and model.
    for (genvar r = 0; r < REGION_COUNT; r++) begin : g_region
        assign tbl_first[r]  = region_group(REGION_W'(r), 1'b0);
        assign tbl_second[r] = region_group(REGION_W'(r), 1'b1);
    end

    logic [REGION_W-1:0] src_region;
    logic [REGION_W-1:0] cpu_region;
    grp_e                src_grp;
    grp_e                cpu_grp;
    logic                same_bus;
    logic                in_window;

    assign src_region = src[ADDR_W-1:REG_LSB];
    assign cpu_region = cpu_addr[ADDR_W-1:REG_LSB];

    // Group lookup for the copy source and the processor access.
    always_comb begin
        src_grp = model_sel ? tbl_second[src_region] : tbl_first[src_region];
        cpu_grp = model_sel ? tbl_second[cpu_region] : tbl_first[cpu_region];
    end

    // Contention on a shared external group, and the object-memory window.
    assign same_bus  = (src_grp != GRP_CORE) && (src_grp == cpu_grp);
    assign in_window = (cpu_addr >= OBJ_BASE) &&
                       (cpu_addr <  OBJ_BASE + ADDR_W'(OBJ_SPAN));

    // Final block decision, only while the copy is active.
    assign block = active && (same_bus || in_window);

endmodule

// File: rtl/objcopy_dma.sv
// Module: objcopy_dma (top)
// Object attribute memory copy engine: accepts a page trigger, paces a
// fixed-length byte copy from the system bus into object memory and
// filters processor accesses that would contend with it.
// Assumes the system bus returns bus_rdata in the same cycle as bus_rd.
module objcopy_dma #(
    parameter int unsigned XFER_LEN   = 160,
    parameter int unsigned START_DLY  = 8,
    parameter int unsigned BYTE_GAP   = 4,
    parameter logic [7:0]  LIMIT_PAGE = 8'hF1,
    parameter logic [15:0] OBJ_BASE   = 16'hFE00,
    localparam int unsigned ADDR_W    = 16,
    localparam int unsigned DATA_W    = 8,
    localparam int unsigned IDX_W     = 8,
    localparam int unsigned CNT_W     = $clog2(XFER_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_valid,
    input  logic [7:0]        trig_page,
    input  logic              model_sel,
    output logic              bus_rd,
    output logic [15:0]       bus_addr,
    input  logic [7:0]        bus_rdata,
    output logic              mem_wr,
    output logic [7:0]        mem_idx,
    output logic [7:0]        mem_wdata,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_rdata_in,
    output logic [7:0]        cpu_rdata,
    output logic              cpu_wr_pass,
    output logic              cpu_block,
    output logic              busy,
    output logic [7:0]        remaining
);

    logic              start;
    logic              slot;
    logic              active;
    logic [CNT_W-1:0]  rem;
    logic [ADDR_W-1:0] src;
    logic [IDX_W-1:0]  dst;
    logic              block;

    // Trigger acceptance: pages beyond the limit never start a copy.
    assign start = trig_valid && (trig_page <= LIMIT_PAGE);

    objcopy_sched #(
        .XFER_LEN (XFER_LEN),
        .START_DLY(START_DLY),
        .BYTE_GAP (BYTE_GAP)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .slot     (slot),
        .active   (active),
        .remaining(rem)
    );

    objcopy_addr #(
        .XFER_LEN(XFER_LEN),
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W)
    ) u_addr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .page (trig_page),
        .slot (slot),
        .src  (src),
        .dst  (dst)
    );

    objcopy_guard #(
        .ADDR_W  (ADDR_W),
        .OBJ_BASE(OBJ_BASE),
        .OBJ_SPAN(XFER_LEN)
    ) u_guard (
        .active   (active),
        .model_sel(model_sel),
        .src      (src),
        .cpu_addr (cpu_addr),
        .block    (block)
    );

    // Copy-side outputs: read and write happen in the same slot cycle.
    assign bus_rd    = slot;
    assign bus_addr  = src;
    assign mem_wr    = slot;
    assign mem_idx   = dst;
    assign mem_wdata = bus_rdata;

    // Processor-side filtering of read data and write strobe.
    assign cpu_rdata   = block ? {DATA_W{1'b1}} : cpu_rdata_in;
    assign cpu_wr_pass = cpu_wr && !block;
    assign cpu_block   = block;

    assign busy      = active;
    assign remaining = 8'(rem);

    // R2: an accepted trigger shows a full count on the next cycle.
    p_start_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && remaining == 8'(XFER_LEN)));

    // R3: an out-of-range trigger while idle leaves the engine idle.
    p_ignore_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_page > LIMIT_PAGE && !busy) |=> !busy);

    // R5: index plus remaining count always spans one transfer.
    p_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(mem_idx) + int'(remaining) == XFER_LEN));

    // R10: the object window is closed to the processor during a copy.
    p_window_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_addr >= OBJ_BASE && cpu_addr < OBJ_BASE + 16'(XFER_LEN))
        |-> cpu_block);

    // R11: a blocked access reads all-ones and writes nothing.
    p_blocked_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_block |-> (cpu_rdata == 8'hFF && !cpu_wr_pass));

    // R12: nothing is blocked while idle.
    p_idle_open_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cpu_block);

endmodule

// File: tb/objcopy_dma_test.sv
`timescale 1ns/1ps
module objcopy_dma_test;

    localparam int XFER = 160;
    localparam int NVEC = 16;

    // {model, page, cpu_addr, expected block}
    localparam logic [25:0] VEC [NVEC] = '{
        {1'b0, 8'hC0, 16'hC123, 1'b1},  // R7 main vs main
        {1'b0, 8'hC0, 16'h0150, 1'b1},  // R7 main vs main
        {1'b0, 8'hC0, 16'h8000, 1'b0},  // R7 video differs
        {1'b0, 8'hC0, 16'hE010, 1'b0},  // R7 core differs
        {1'b1, 8'hC0, 16'hC123, 1'b1},  // R8 separate ram group
        {1'b1, 8'hC0, 16'h0150, 1'b0},  // R8 ram vs main
        {1'b1, 8'hC0, 16'hA000, 1'b0},  // R8 ram vs main
        {1'b1, 8'h00, 16'hA010, 1'b1},  // R8 main vs main
        {1'b0, 8'h80, 16'h9FFF, 1'b1},  // R7 video vs video
        {1'b0, 8'h80, 16'h0100, 1'b0},  // R7 video vs main
        {1'b0, 8'hE0, 16'hE050, 1'b0},  // R9 core source never contends
        {1'b0, 8'hE0, 16'hFE10, 1'b1},  // R10 window
        {1'b1, 8'h00, 16'hFEA0, 1'b0},  // R10 just past window
        {1'b0, 8'h00, 16'hFE9F, 1'b1},  // R10 last window byte
        {1'b0, 8'hF1, 16'hD000, 1'b0},  // R9 top page is core
        {1'b1, 8'hE0, 16'hC000, 1'b0}   // R9 core source, model 1
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_valid = 1'b0;
    logic [7:0]  trig_page = 8'h00;
    logic        model_sel = 1'b0;
    logic        bus_rd;
    logic [15:0] bus_addr;
    logic [7:0]  bus_rdata;
    logic        mem_wr;
    logic [7:0]  mem_idx;
    logic [7:0]  mem_wdata;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata_in = 8'h5A;
    logic [7:0]  cpu_rdata;
    logic        cpu_wr_pass;
    logic        cpu_block;
    logic        busy;
    logic [7:0]  remaining;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int trig_cyc = 0;
    int wr_count = 0;
    int first_cyc = 0;
    int last_cyc  = 0;
    int gap_err   = 0;
    logic [7:0] objmem [256];

    always #2 clk = ~clk;

    objcopy_dma uut (
        .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_page(trig_page),
        .model_sel(model_sel), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_rdata(bus_rdata), .mem_wr(mem_wr), .mem_idx(mem_idx),
        .mem_wdata(mem_wdata), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_rdata_in(cpu_rdata_in), .cpu_rdata(cpu_rdata),
        .cpu_wr_pass(cpu_wr_pass), .cpu_block(cpu_block), .busy(busy),
        .remaining(remaining)
    );

    // Source memory model: a byte pattern derived from the address.
    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[15:8] ^ a[7:0] ^ 8'h3C;
    endfunction
    assign bus_rdata = pat(bus_addr);

    always @(posedge clk) cyc <= cyc + 1;

    // Object memory model and write-timing log, sampled mid-cycle.
    always @(negedge clk) begin
        if (mem_wr) begin
            objmem[mem_idx] <= mem_wdata;
            if (wr_count == 0) first_cyc <= cyc;
            else if (cyc - last_cyc != 4) gap_err <= gap_err + 1;
            last_cyc <= cyc;
            wr_count <= wr_count + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        @(negedge clk);
        wr_count = 0;
        gap_err  = 0;
        for (int i = 0; i < 256; i++) objmem[i] = 8'h00;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic trigger(input logic [7:0] page);
        @(negedge clk);
        trig_valid = 1'b1;
        trig_page  = page;
        @(posedge clk);
        @(negedge clk);
        trig_cyc   = cyc;
        trig_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_copy(input string req, input logic [7:0] page);
        int bad = 0;
        for (int k = 0; k < XFER; k++)
            if (objmem[k] != pat({page, 8'(k)})) bad++;
        for (int k = XFER; k < 256; k++)
            if (objmem[k] != 8'h00) bad++;
        check(req, bad, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1: reset state
        check("R1 busy", busy, 0);
        check("R1 remaining", remaining, 0);
        check("R1 mem_wr", mem_wr, 0);
        check("R1 bus_rd", bus_rd, 0);

        // Vector table: group tables and window while a copy runs.
        for (int v = 0; v < NVEC; v++) begin
            do_reset();
            @(negedge clk);
            model_sel = VEC[v][25];
            trigger(VEC[v][24:17]);
            cpu_addr = VEC[v][16:1];
            cpu_rd = 1'b1;
            cpu_wr = 1'b1;
            #1;
            check("R9 block", cpu_block, VEC[v][0]);
            check("R11 rdata", cpu_rdata, VEC[v][0] ? 8'hFF : 8'h5A);
            check("R11 wr_pass", cpu_wr_pass, !VEC[v][0]);
            cpu_rd = 1'b0;
            cpu_wr = 1'b0;
        end

        // Full copy, model 0, page 0xC0.
        do_reset();
        model_sel = 1'b0;
        clear_log();
        trigger(8'hC0);
        check("R2 busy", busy, 1);
        check("R2 remaining", remaining, XFER);
        wait_idle();
        check("R4 first delay", first_cyc - trig_cyc, 7);
        check("R4 gaps", gap_err, 0);
        check("R5 count", wr_count, XFER);
        check("R5 busy low", busy, 0);
        check("R5 span", last_cyc - first_cyc, 4 * (XFER - 1));
        check_copy("R5 data", 8'hC0);

        // R12: idle, window and same-group accesses pass.
        cpu_addr = 16'hFE00;
        cpu_rd = 1'b1;
        #1;
        check("R12 idle window", cpu_block, 0);
        check("R12 idle rdata", cpu_rdata, 8'h5A);
        cpu_rd = 1'b0;

        // R3: page above the limit is ignored.
        clear_log();
        trigger(8'hF2);
        repeat (20) @(negedge clk);
        check("R3 busy", busy, 0);
        check("R3 writes", wr_count, 0);

        // R2: the limit page itself is accepted.
        clear_log();
        trigger(8'hF1);
        check("R2 limit busy", busy, 1);
        wait_idle();
        check_copy("R2 limit data", 8'hF1);

        // R6: restart mid-copy.
        clear_log();
        trigger(8'h10);
        repeat (30) @(negedge clk);
        wr_count = 0;
        gap_err = 0;
        trigger(8'h20);
        check("R6 remaining", remaining, XFER);
        wait_idle();
        check("R6 first delay", first_cyc - trig_cyc, 7);
        check("R6 count", wr_count, XFER);
        check_copy("R6 data", 8'h20);

        // R1: reset in mid-copy returns to idle.
        trigger(8'h40);
        repeat (10) @(negedge clk);
        do_reset();
        @(negedge clk);
        check("R1 mid reset busy", busy, 0);
        check("R1 mid reset remaining", remaining, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule